// File: doc/BRIEF.md
# Level-Sensitive Vectored Interrupt Controller

This block collects 96 level-sensitive interrupt lines into three banks of 32 and drives two request lines toward a processor: a normal request and a fast request. Software controls each line with a mask bit and a fast-route select bit. Every cycle the block also computes a byte-offset vector that points at the lowest-numbered line that is pending and not masked. The processor can jump through this vector without scanning the banks.

Access is through a simple single-cycle register port. The port takes a word address, a write strobe and write data, and its read data is combinational from the registered state. Pending bits follow the input levels exactly, so software cannot clear them. A source is silenced by removing its cause or by masking it. A separate fast-pending bank latches fast-routed events, and software clears it by writing ones. Two plain storage words (protect and NMI configuration) and a base-address word complete the map.

Top module: `lvl_intc`

## Requirements
- R1: Source n sits in bank n/32 at bit n%32. Registers are addressed by word address `bus_word`, which is the byte offset divided by 4. Its bits [5:2] select the group: 0 control, 1 pending, 2 fast-pending, 3 select, 5 mask. Its bits [1:0] select the bank in a banked group. In the control group, slot 0 is the vector, 1 is the base address, 2 is protect and 3 is NMI. Byte offsets are vector 0x00, base 0x04, protect 0x08, NMI 0x0C, pending 0x10-0x18, fast-pending 0x20-0x28, select 0x30-0x38 and mask 0x50-0x58.
- R2: A pending bit equals the level of its input at the previous clock edge. It sets while the input is high and clears when the input is low, with no latching.
- R3: `irq_o` is high one clock after any source is high with its mask bit clear.
- R4: `fiq_o` is high one clock after any source is high with its mask bit clear and its select bit set.
- R5: The vector (read at slot 0 and driven on `vec_o`) equals 4 times the index of the lowest-numbered pending unmasked source. It is 0 when no such source exists. It updates on the same edge as the outputs.
- R6: Writes to the vector register leave it unchanged.
- R7: Writes to the pending registers have no effect.
- R8: A fast-pending bit is set by a source that is high, unmasked and selected. Writing 1 to the bit clears it, and writing 0 leaves it alone. A source that is still active sets the bit again.
- R9: A write to the base-address register stores the data with bits [1:0] forced to 0.
- R10: After reset, every register reads 0, and `irq_o`, `fiq_o` and `vec_o` are 0.
- R11: Protect and NMI are 32-bit read/write storage words. A banked access with bank index 3 reads 0, and a write to it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 96 | Level-sensitive interrupt sources |
| bus_we | input | 1 | Write strobe for the register port |
| bus_word | input | 6 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_o | output | 32 | Byte-offset vector of lowest pending unmasked source |

## Verification
On every cycle the assertions check several relations:
- The pending bank mirrors the previous input levels.
- Both request lines agree with pending, mask and select.
- A fast request implies a normal request.
- The vector is word aligned, in range, zero when idle, and always names a source that is pending and unmasked.

Only the bench scenarios can show three behaviours:
- The vector picks the lowest such source rather than just any valid one.
- Writes to read-only or out-of-range locations leave state untouched.
- Write-one-to-clear keeps the bits written with 0, and the base register drops its low bits.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

    // Register groups, taken from word-address bits [5:2]
    localparam logic [3:0] GRP_CTRL  = 4'h0;
    localparam logic [3:0] GRP_PEND  = 4'h1;
    localparam logic [3:0] GRP_FAST  = 4'h2;
    localparam logic [3:0] GRP_SEL   = 4'h3;
    localparam logic [3:0] GRP_MASK  = 4'h5;

    // Slots inside the control group
    localparam logic [1:0] SLOT_VEC  = 2'd0;
    localparam logic [1:0] SLOT_BASE = 2'd1;
    localparam logic [1:0] SLOT_PROT = 2'd2;
    localparam logic [1:0] SLOT_NMI  = 2'd3;

endpackage

// File: rtl/lvl_intc_prio.sv
// Lowest-index-first priority encoder.
module lvl_intc_prio #(
    parameter int N     = 96,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lvl_intc_rdmux.sv
// Read-data selection from registered state.
module lvl_intc_rdmux
    import lvl_intc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 32,
    parameter int VEC_W     = 9,
    localparam int NUM_SRC  = NUM_BANKS * DATA_W
) (
    input  logic [3:0]         grp,
    input  logic [1:0]         slot,
    input  logic [VEC_W-1:0]   vec,
    input  logic [DATA_W-1:0]  base,
    input  logic [DATA_W-1:0]  prot,
    input  logic [DATA_W-1:0]  nmi,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] fpend,
    input  logic [NUM_SRC-1:0] sel,
    input  logic [NUM_SRC-1:0] mask,
    output logic [DATA_W-1:0]  rdata
);
    logic [NUM_SRC-1:0] banked;

    always_comb begin
        unique case (grp)
            GRP_PEND: banked = pend;
            GRP_FAST: banked = fpend;
            GRP_SEL:  banked = sel;
            GRP_MASK: banked = mask;
            default:  banked = '0;
        endcase
    end

    always_comb begin
        rdata = '0;
        if (grp == GRP_CTRL) begin
            unique case (slot)
                SLOT_VEC:  rdata = DATA_W'(vec);
                SLOT_BASE: rdata = base;
                SLOT_PROT: rdata = prot;
                SLOT_NMI:  rdata = nmi;
                default:   rdata = '0;
            endcase
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (slot == 2'(b)) rdata = banked[b*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/lvl_intc.sv
// Level-sensitive vectored interrupt controller, top level.
module lvl_intc
    import lvl_intc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*DATA_W-1:0]   src_i,
    input  logic                          bus_we,
    input  logic [5:0]                    bus_word,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    output logic                          irq_o,
    output logic                          fiq_o,
    output logic [DATA_W-1:0]             vec_o
);
    localparam int NUM_SRC = NUM_BANKS * DATA_W;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int VEC_W   = IDX_W + 2;

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] fpend;
        logic [NUM_SRC-1:0] sel;
        logic [NUM_SRC-1:0] mask;
        logic [DATA_W-1:0]  base;
        logic [DATA_W-1:0]  prot;
        logic [DATA_W-1:0]  nmi;
        logic               irq;
        logic               fiq;
        logic [VEC_W-1:0]   vec;
    } state_t;

    state_t st_d, st_q;

    logic [3:0] grp;
    logic [1:0] slot;
    assign grp  = bus_word[5:2];
    assign slot = bus_word[1:0];

    // Register-write decode: next values of software-owned fields
    logic [NUM_SRC-1:0] sel_nxt, mask_nxt, clr_fast;
    logic [DATA_W-1:0]  base_nxt, prot_nxt, nmi_nxt;

    always_comb begin
        sel_nxt  = st_q.sel;
        mask_nxt = st_q.mask;
        clr_fast = '0;
        base_nxt = st_q.base;
        prot_nxt = st_q.prot;
        nmi_nxt  = st_q.nmi;
        if (bus_we) begin
            if (grp == GRP_CTRL) begin
                unique case (slot)
                    SLOT_BASE: base_nxt = {bus_wdata[DATA_W-1:2], 2'b00};
                    SLOT_PROT: prot_nxt = bus_wdata;
                    SLOT_NMI:  nmi_nxt  = bus_wdata;
                    default:   ; // vector slot is read-only
                endcase
            end
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (slot == 2'(b)) begin
                    unique case (grp)
                        GRP_SEL:  sel_nxt[b*DATA_W +: DATA_W]  = bus_wdata;
                        GRP_MASK: mask_nxt[b*DATA_W +: DATA_W] = bus_wdata;
                        GRP_FAST: clr_fast[b*DATA_W +: DATA_W] = bus_wdata;
                        default:  ; // pending is read-only
                    endcase
                end
            end
        end
    end

    logic [NUM_SRC-1:0] live;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;

    assign live = src_i & ~mask_nxt;

    lvl_intc_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .req   (live),
        .found (hit),
        .idx   (hit_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pend  = src_i;
        st_d.sel   = sel_nxt;
        st_d.mask  = mask_nxt;
        st_d.base  = base_nxt;
        st_d.prot  = prot_nxt;
        st_d.nmi   = nmi_nxt;
        st_d.fpend = (st_q.fpend & ~clr_fast) | (live & sel_nxt);
        st_d.irq   = |live;
        st_d.fiq   = |(live & sel_nxt);
        st_d.vec   = hit ? {hit_idx, 2'b00} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    lvl_intc_rdmux #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_rd (
        .grp   (grp),
        .slot  (slot),
        .vec   (st_q.vec),
        .base  (st_q.base),
        .prot  (st_q.prot),
        .nmi   (st_q.nmi),
        .pend  (st_q.pend),
        .fpend (st_q.fpend),
        .sel   (st_q.sel),
        .mask  (st_q.mask),
        .rdata (bus_rdata)
    );

    // Plain views of state for the bound checker
    logic [NUM_SRC-1:0] pend_w, sel_w, mask_w;
    assign pend_w = st_q.pend;
    assign sel_w  = st_q.sel;
    assign mask_w = st_q.mask;

    assign irq_o = st_q.irq;
    assign fiq_o = st_q.fiq;
    assign vec_o = DATA_W'(st_q.vec);
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
    parameter int NUM_SRC = 96,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] sel,
    input logic [NUM_SRC-1:0] mask,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [DATA_W-1:0]  vec_o
);
    localparam int IDX_W = $clog2(NUM_SRC);

    p_pend_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pend == $past(src_i));

    p_irq_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(pend & ~mask));

    p_fiq_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == |(pend & ~mask & sel));

    p_fiq_implies_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    p_vec_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vec_o == '0);

    p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_o[1:0] == 2'b00 && vec_o < DATA_W'(NUM_SRC * 4));

    p_vec_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend[vec_o[IDX_W+1:2]] && !mask[vec_o[IDX_W+1:2]]));
endmodule

bind lvl_intc lvl_intc_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .pend  (pend_w),
    .sel   (sel_w),
    .mask  (mask_w),
    .irq_o (irq_o),
    .fiq_o (fiq_o),
    .vec_o (vec_o)
);

// File: tb/lvl_intc_test.sv
`timescale 1ns/1ps
module lvl_intc_test;
    localparam int NB = 3;
    localparam int DW = 32;
    localparam int NS = NB * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          we = 1'b0;
    logic [5:0]    word = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata, vec;
    logic          irq, fiq;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    lvl_intc #(.NUM_BANKS(NB), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_we(we), .bus_word(word),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq), .vec_o(vec)
    );

    always #5 clk = ~clk;

    // Reference model
    logic [NS-1:0] m_pend = '0, m_fp = '0, m_sel = '0, m_mask = '0;
    logic [DW-1:0] m_base = '0, m_prot = '0, m_nmi = '0;

    function automatic logic [DW-1:0] exp_vec(input logic [NS-1:0] p, input logic [NS-1:0] m);
        for (int i = 0; i < NS; i++) if (p[i] && !m[i]) return DW'(i * 4);
        return '0;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [5:0] a);
        logic [3:0] g = a[5:2];
        int s = int'(a[1:0]);
        if (g == 4'h0) begin
            case (s)
                0: return exp_vec(m_pend, m_mask);
                1: return m_base;
                2: return m_prot;
                default: return m_nmi;
            endcase
        end
        if (s >= NB) return '0;
        case (g)
            4'h1: return m_pend[s*DW +: DW];
            4'h2: return m_fp[s*DW +: DW];
            4'h3: return m_sel[s*DW +: DW];
            4'h5: return m_mask[s*DW +: DW];
            default: return '0;
        endcase
    endfunction

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One clock: inputs already driven; update model at edge, check after.
    task automatic step();
        logic [NS-1:0] clr;
        @(posedge clk);
        clr = '0;
        if (we) begin
            int s = int'(word[1:0]);
            if (word[5:2] == 4'h0) begin
                if (s == 1) m_base = {wdata[DW-1:2], 2'b00};
                if (s == 2) m_prot = wdata;
                if (s == 3) m_nmi  = wdata;
            end else if (s < NB) begin
                if (word[5:2] == 4'h3) m_sel[s*DW +: DW]  = wdata;
                if (word[5:2] == 4'h5) m_mask[s*DW +: DW] = wdata;
                if (word[5:2] == 4'h2) clr[s*DW +: DW]    = wdata;
            end
        end
        m_fp   = (m_fp & ~clr) | (src & m_sel & ~m_mask);
        m_pend = src;
        @(negedge clk);
        we = 1'b0;
        check("R3 irq", DW'(irq), DW'(|(m_pend & ~m_mask)));
        check("R4 fiq", DW'(fiq), DW'(|(m_pend & ~m_mask & m_sel)));
        check("R5 vec", vec, exp_vec(m_pend, m_mask));
    endtask

    task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
        word = a; wdata = d; we = 1'b1;
        step();
    endtask

    task automatic rd(input string req, input logic [5:0] a);
        word = a; we = 1'b0;
        #1;
        check(req, rdata, exp_read(a));
    endtask

    initial begin
        void'($urandom(32'd20240417));
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 irq", DW'(irq), '0);
        check("R10 fiq", DW'(fiq), '0);
        check("R10 vec", vec, '0);
        rst_n = 1'b1;
        for (int a = 0; a < 64; a++) rd("R10 read", 6'(a));

        // R1/R5: single sources at bank edges
        src = '0; src[0] = 1'b1; step();
        check("R5 vec src0", vec, 32'd0);
        check("R3 irq src0", DW'(irq), 32'd1);
        src = '0; src[95] = 1'b1; step();
        check("R1 vec src95", vec, 32'd380);
        rd("R1 pend bank2", 6'h06);
        src[33] = 1'b1; step();
        check("R5 lowest", vec, 32'd132);
        // R2: level drop clears pending
        src = '0; step();
        rd("R2 pend cleared", 6'h04);
        check("R2 irq low", DW'(irq), '0);

        // masking and fast routing
        src[40] = 1'b1; src[70] = 1'b1;
        wr(6'h15, 32'h0000_0100);            // mask bit 40 (bank1 bit8)
        check("R5 masked skip", vec, 32'd280);
        wr(6'h0E, 32'h0000_0040);            // select bit 70 (bank2 bit6)
        check("R4 fiq on", DW'(fiq), 32'd1);
        rd("R8 fast set", 6'h0A);
        src[70] = 1'b0;
        wr(6'h0A, 32'h0000_0000);            // writing 0 keeps bit
        rd("R8 w0 keeps", 6'h0A);
        wr(6'h0A, 32'h0000_0040);            // W1C
        rd("R8 w1c", 6'h0A);

        // R6, R7: read-only locations
        src = '0; src[5] = 1'b1; step();
        wr(6'h00, 32'hFFFF_FFFF);
        rd("R6 vec ro", 6'h00);
        check("R6 vec port", vec, 32'd20);
        wr(6'h04, 32'h0000_0020);
        rd("R7 pend ro", 6'h04);
        // R9 base, R11 storage and bank 3
        wr(6'h01, 32'hDEAD_BEEF);
        rd("R9 base", 6'h01);
        wr(6'h02, 32'h1234_5677);
        rd("R11 prot", 6'h02);
        wr(6'h03, 32'hA5A5_5A5B);
        rd("R11 nmi", 6'h03);
        wr(6'h17, 32'hFFFF_FFFF);
        rd("R11 bank3 mask", 6'h17);
        check("R11 bank3 no effect", vec, 32'd20);

        // random phase
        for (int it = 0; it < 600; it++) begin
            src = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
                   $urandom & $urandom & $urandom};
            if (($urandom % 2) == 0) begin
                logic [3:0] grps [6] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h5, 4'h5};
                word  = {grps[$urandom % 6], 2'($urandom)};
                wdata = $urandom | $urandom;
                we    = 1'b1;
            end
            step();
            rd("R1 random read", 6'($urandom));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule